// File: doc/BRIEF.md
# Switch Mode Control Register

A single 16-bit read/write configuration word for a packet switch, reached over a plain local-processor bus. The bus has an address, a write strobe, write data and combinational read data. A flush input brings the word back to its power-on value. The stored fields drive the switch's control lines:
- the embedded controller reset hold
- flow-control checking
- the forced idle-packet colour and the idle colour itself
- the colour expected on incoming packets
- the global interrupt mask
- the standby state

Standby holds the functional units in reset while the configuration stays writable.

The block also drives the active-low interrupt pin from an interrupt-status vector. When at least one status bit is set and the mask is clear, the pin is driven low. In every other case it is released to high impedance, and an external pull-up holds the line high. The status vector itself is produced and latched elsewhere. The mask only changes what the pin shows.

Bit numbering below is the usual one, with bit 15 as the most significant bit of the data bus.

Top module: `sw_mode_ctrl`

## Requirements
- R1: After asynchronous reset, a read at the register offset returns 16'h0141. In that state proc_rst_o and standby_o are 1 and every other control output is 0.
- R2: Read bits [15:8] always return the version parameter (default 1). Writes to those bits have no effect.
- R3: Read bit 7 is reserved. It always reads 0, and writing it has no effect.
- R4: A write at the register offset updates the following outputs on the next clock edge:
  - proc_rst_o from write bit 6
  - flow_chk_o from bit 5
  - idle_force_o from bit 4
  - idle_color_o from bit 3 (0 blue, 1 red)
  - exp_color_o from bit 2 (0 blue, 1 red)
  - irq_mask_o from bit 1
- R5: Writing 0 to bit 0 clears standby_o. Writing 1 to bit 0 leaves standby_o unchanged, so a register write can never set standby.
- R6: A cycle with flush_i high restores the reset value of R1 on the next edge. It takes priority over a write in the same cycle.
- R7: A write with any address other than the register offset changes nothing. A read at any other address returns 0.
- R8: When irq_mask_o is 0 and any bit of irq_stat_i is 1, irq_oe_o is 1 and irq_n_o is 0, in the same cycle. Otherwise irq_oe_o is 0 and irq_n_o is 1.
- R9: A read at the register offset returns the current controls in their bit positions: standby in bit 0 and the R4 fields in bits 6 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Bus address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational on addr_i |
| flush_i | input | 1 | Synchronous flush reset of the register |
| irq_stat_i | input | IRQ_W | Interrupt status bits from the status logic |
| proc_rst_o | output | 1 | Holds the embedded controller in reset |
| flow_chk_o | output | 1 | Enables flow-control checking |
| idle_force_o | output | 1 | Forces the colour of idle packets |
| idle_color_o | output | 1 | Idle packet colour, 0 blue, 1 red |
| exp_color_o | output | 1 | Expected incoming colour, 0 blue, 1 red |
| irq_mask_o | output | 1 | Global interrupt mask |
| standby_o | output | 1 | Holds functional units in reset |
| irq_n_o | output | 1 | Interrupt pin level, active low |
| irq_oe_o | output | 1 | Interrupt pin output enable; 0 releases the pin |

## Verification
The bench builds the block with a 4-bit address, an 8-bit status vector, version 1 and offset 0.

Because the address is narrow, random traffic lands on the offset about half the time and on other addresses the rest of the time. That exercises both the decode and the R7 checks.

With only eight status lines, all-zero and single-bit status patterns occur often. Together with random mask toggles and flushes that collide with writes, this covers every pin state and the flush-over-write priority.

// File: rtl/sw_mode_pkg.sv
package sw_mode_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned CTL_W  = 6;

  // control field order matches write bits [6:1]
  typedef struct packed {
    logic proc_rst;
    logic flow_chk;
    logic idle_force;
    logic idle_color;
    logic exp_color;
    logic irq_mask;
  } ctl_t;

  localparam ctl_t CTL_RST = '{proc_rst: 1'b1, default: 1'b0};

  function automatic logic [DATA_W-1:0] pack_word(input logic [7:0] ver,
                                                  input ctl_t ctl,
                                                  input logic stby);
    return {ver, 1'b0, ctl, stby};
  endfunction
endpackage

// File: rtl/sw_mode_dec.sv
module sw_mode_dec #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned REG_OFF = 0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              hit_o,
  output logic              wr_o
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFF);

  always_comb begin
    hit_o = (addr_i == OFF);
    wr_o  = hit_o & we_i;
  end
endmodule

// File: rtl/sw_mode_fields.sv
module sw_mode_fields
  import sw_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wctl_i,
  input  logic             wstby_i,
  output ctl_t             ctl_o,
  output logic             stby_o
);
  localparam logic [CTL_W-1:0] RST_BITS = CTL_RST;

  logic [CTL_W-1:0] ctl_q;

  for (genvar i = 0; i < CTL_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ctl_q[i] <= RST_BITS[i];
      else if (flush_i) ctl_q[i] <= RST_BITS[i];
      else if (wr_i)    ctl_q[i] <= wctl_i[i];
    end
  end

  // standby: set only by reset or flush, cleared by writing 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stby_o <= 1'b1;
    else if (flush_i) stby_o <= 1'b1;
    else if (wr_i)    stby_o <= stby_o & wstby_i;
  end

  assign ctl_o = ctl_t'(ctl_q);
endmodule

// File: rtl/sw_mode_irq.sv
module sw_mode_irq #(
  parameter int unsigned IRQ_W = 8
) (
  input  logic [IRQ_W-1:0] stat_i,
  input  logic             mask_i,
  output logic             irq_n_o,
  output logic             irq_oe_o
);
  logic any_set;

  always_comb begin
    any_set  = |stat_i;
    irq_oe_o = any_set & ~mask_i;
    irq_n_o  = ~irq_oe_o;
  end
endmodule

// File: rtl/sw_mode_ctrl.sv
module sw_mode_ctrl
  import sw_mode_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned IRQ_W   = 8,
  parameter int unsigned REG_OFF = 0,
  parameter logic [7:0]  VERSION = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  input  logic              flush_i,
  input  logic [IRQ_W-1:0]  irq_stat_i,
  output logic              proc_rst_o,
  output logic              flow_chk_o,
  output logic              idle_force_o,
  output logic              idle_color_o,
  output logic              exp_color_o,
  output logic              irq_mask_o,
  output logic              standby_o,
  output logic              irq_n_o,
  output logic              irq_oe_o
);
  logic hit, wr;
  ctl_t ctl;
  logic stby;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[15:7];

  sw_mode_dec #(.ADDR_W(ADDR_W), .REG_OFF(REG_OFF)) i_dec (
    .addr_i (addr_i),
    .we_i   (we_i),
    .hit_o  (hit),
    .wr_o   (wr)
  );

  sw_mode_fields i_fields (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .wr_i    (wr),
    .wctl_i  (wdata_i[6:1]),
    .wstby_i (wdata_i[0]),
    .ctl_o   (ctl),
    .stby_o  (stby)
  );

  sw_mode_irq #(.IRQ_W(IRQ_W)) i_irq (
    .stat_i   (irq_stat_i),
    .mask_i   (ctl.irq_mask),
    .irq_n_o  (irq_n_o),
    .irq_oe_o (irq_oe_o)
  );

  assign rdata_o      = hit ? pack_word(VERSION, ctl, stby) : '0;
  assign proc_rst_o   = ctl.proc_rst;
  assign flow_chk_o   = ctl.flow_chk;
  assign idle_force_o = ctl.idle_force;
  assign idle_color_o = ctl.idle_color;
  assign exp_color_o  = ctl.exp_color;
  assign irq_mask_o   = ctl.irq_mask;
  assign standby_o    = stby;
endmodule

// File: rtl/sw_mode_ctrl_chk.sv
module sw_mode_ctrl_chk #(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned IRQ_W   = 8,
  parameter int unsigned REG_OFF = 0,
  parameter logic [7:0]  VERSION = 8'h01
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [15:0]       wdata_i,
  input logic [15:0]       rdata_o,
  input logic              flush_i,
  input logic [IRQ_W-1:0]  irq_stat_i,
  input logic              proc_rst_o,
  input logic              flow_chk_o,
  input logic              irq_mask_o,
  input logic              standby_o,
  input logic              irq_n_o,
  input logic              irq_oe_o
);
  localparam logic [ADDR_W-1:0] OFF = ADDR_W'(REG_OFF);

  p_version_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == OFF |-> rdata_o[15:8] == VERSION);

  p_rsvd_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[7]);

  p_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFF && !flush_i) |=> flow_chk_o == $past(wdata_i[5]));

  p_no_set_stby_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !standby_o) |=> !standby_o);

  p_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (standby_o && proc_rst_o && !irq_mask_o && !flow_chk_o));

  p_other_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != OFF && !flush_i) |=> ($stable(standby_o) && $stable(irq_mask_o) &&
                                     $stable(proc_rst_o)));

  p_masked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mask_o |-> (!irq_oe_o && irq_n_o));

  p_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_mask_o && irq_stat_i != '0) |-> (irq_oe_o && !irq_n_o));
endmodule

bind sw_mode_ctrl sw_mode_ctrl_chk #(
  .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .REG_OFF(REG_OFF), .VERSION(VERSION)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .we_i       (we_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .flush_i    (flush_i),
  .irq_stat_i (irq_stat_i),
  .proc_rst_o (proc_rst_o),
  .flow_chk_o (flow_chk_o),
  .irq_mask_o (irq_mask_o),
  .standby_o  (standby_o),
  .irq_n_o    (irq_n_o),
  .irq_oe_o   (irq_oe_o)
);

// File: tb/test_sw_mode_ctrl.sv
module test_sw_mode_ctrl;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned IRQ_W  = 8;
  localparam logic [7:0]  VER    = 8'h01;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              we_i = 1'b0;
  logic [15:0]       wdata_i = '0;
  logic [15:0]       rdata_o;
  logic              flush_i = 1'b0;
  logic [IRQ_W-1:0]  irq_stat_i = '0;
  logic proc_rst_o, flow_chk_o, idle_force_o, idle_color_o, exp_color_o;
  logic irq_mask_o, standby_o, irq_n_o, irq_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference model: ctl bits [5:0] map to write bits [6:1]
  logic [5:0] m_ctl;
  logic       m_stby;

  always #10 clk_i = ~clk_i;

  sw_mode_ctrl #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .REG_OFF(0), .VERSION(VER)) i_sw_mode_ctrl (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o, .flush_i, .irq_stat_i,
    .proc_rst_o, .flow_chk_o, .idle_force_o, .idle_color_o, .exp_color_o,
    .irq_mask_o, .standby_o, .irq_n_o, .irq_oe_o
  );

  function automatic logic [15:0] exp_rdata(input logic [ADDR_W-1:0] a);
    return (a == '0) ? {VER, 1'b0, m_ctl, m_stby} : 16'h0000;
  endfunction

  function automatic logic exp_oe();
    return (irq_stat_i != '0) && !m_ctl[0];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctl  = 6'b100000;
    m_stby = 1'b1;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R9 rdata"}, rdata_o, exp_rdata(addr_i));
    chk({tag, " R4 ctl"}, {10'd0, proc_rst_o, flow_chk_o, idle_force_o,
                           idle_color_o, exp_color_o, irq_mask_o}, {10'd0, m_ctl});
    chk({tag, " R5 standby"}, {15'd0, standby_o}, {15'd0, m_stby});
    chk({tag, " R8 irq"}, {14'd0, irq_oe_o, irq_n_o}, {14'd0, exp_oe(), !exp_oe()});
  endtask

  task automatic step(input logic we, input logic [ADDR_W-1:0] a, input logic [15:0] d,
                      input logic fl, input logic [IRQ_W-1:0] st, input string tag);
    we_i = we; addr_i = a; wdata_i = d; flush_i = fl; irq_stat_i = st;
    @(posedge clk_i);
    if (fl) model_reset();
    else if (we && a == '0) begin
      m_ctl  = d[6:1];
      m_stby = m_stby & d[0];
    end
    @(negedge clk_i);
    check_all(tag);
  endtask

  initial begin
    model_reset();
    #35;
    chk("R1 reset rdata", rdata_o, 16'h0141);
    chk("R1 reset outputs", {9'd0, proc_rst_o, flow_chk_o, idle_force_o, idle_color_o,
                             exp_color_o, irq_mask_o, standby_o}, 16'h0041);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 post");
    // R2 R3: all ones leave version and reserved bit alone, standby stays set
    step(1'b1, 4'd0, 16'hFFFF, 1'b0, 8'h00, "R2 R3 all ones");
    chk("R2 version", {8'd0, rdata_o[15:8]}, {8'd0, VER});
    chk("R3 reserved", {15'd0, rdata_o[7]}, 16'd0);
    // R5: clear standby, then writing 1 cannot set it
    step(1'b1, 4'd0, 16'h0000, 1'b0, 8'h00, "R5 clear");
    step(1'b1, 4'd0, 16'h0001, 1'b0, 8'h00, "R5 no set");
    chk("R5 standby held low", {15'd0, standby_o}, 16'd0);
    // R8: unmasked status drives pin; masked releases it
    step(1'b0, 4'd0, 16'h0000, 1'b0, 8'h10, "R8 unmasked");
    step(1'b1, 4'd0, 16'h0002, 1'b0, 8'h10, "R8 masked");
    chk("R8 masked released", {15'd0, irq_oe_o}, 16'd0);
    // R7: other address write ignored, reads 0
    step(1'b1, 4'd5, 16'h0000, 1'b0, 8'h01, "R7 other addr");
    chk("R7 mask kept", {15'd0, irq_mask_o}, 16'd1);
    // R6: flush beats write
    step(1'b1, 4'd0, 16'h0000, 1'b1, 8'h00, "R6 flush over write");
    chk("R6 flush value", rdata_o, 16'h0141);
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      logic [IRQ_W-1:0] st;
      a  = ($urandom % 2) ? '0 : ADDR_W'($urandom);
      st = ($urandom % 3 == 0) ? '0 : IRQ_W'(1 << ($urandom % IRQ_W));
      step($urandom % 2 == 0, a, 16'($urandom), ($urandom % 40) == 0, st, "rand R4");
    end
    // asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    addr_i = '0;
    #1;
    chk("R1 async reset", rdata_o, 16'h0141);
    model_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule